// File: doc/BRIEF.md
# BERT Time-Slot Mapping Gate

This block places a bit-error-rate tester inside a framed T1 or E1 serial stream. It follows the bit position inside each frame and raises a transmit strobe and a receive strobe for the positions that belong to the tester. A strobed transmit position takes the generator's bit in place of the through data. A strobed receive position is passed to the checker together with an enable. Each time slot has its own transmit-select bit and its own receive-select bit. In T1 mode the framing bit can also be given to the tester, with a separate enable for each direction.

A direction input sets where the tester attaches. On the network side, generator bits go into the stream toward the line and the checker reads the line's receive data. On the backplane side, generator bits go into the stream toward the backplane and the checker reads the backplane's transmit data. The block takes the mode, the direction, the F-bit enables and both select vectors at the first bit of each frame. A change made during a frame therefore never maps only part of that frame. Recovery of frame alignment is outside this block: the frame sync input marks bit 0.

Position tracking is a small state machine. HUNT is the state after reset and lasts until the first frame sync. FBIT is the T1 framing bit. PAYLOAD covers the channel bits. A frame start is entered on a frame sync from any state, or by itself after the last payload bit. In T1 it goes to FBIT, and in E1 it goes to PAYLOAD slot 0. FBIT always moves to PAYLOAD slot 0. PAYLOAD steps one bit at a time through the slots.

Top module: `bert_slot_gate`

## Requirements
- R1: From reset until the first frame sync, gen_en and chk_en stay 0. net_tx_out repeats bp_tx_in and bp_rx_out repeats net_rx_in, each one cycle later. All registered outputs are 0 while rst_n is low.
- R2: The cycle with fsync high is frame bit 0. A T1 frame is 193 bits: bit 0 is the F-bit and slot k covers bits 1+8k to 8+8k. An E1 frame is 256 bits and slot k covers bits 8k to 8k+7. Without fsync the next frame starts right after the last bit. An fsync in the middle of a frame restarts the count at bit 0.
- R3: In a payload bit of slot k, gen_en is 1 in that same cycle exactly when tx_sel[k] is 1. In T1, bits 24 to 31 of the select vectors are never used.
- R4: chk_en is 1 in the cycle after a payload bit of slot k exactly when rx_sel[k] is 1, and chk_bit then carries that bit from the checker's source side. While chk_en is 0, chk_bit is 0.
- R5: In T1, frame bit 0 is a transmit position when tx_fbit_en is 1 and a receive position when rx_fbit_en is 1. The two enables act independently.
- R6: In E1 the F-bit enables have no effect, and frame bit 0 belongs to slot 0.
- R7: With dir_bkpl = 0 (network side), a transmit position puts gen_bit on net_tx_out one cycle later. bp_rx_out always repeats net_rx_in, and the checker reads net_rx_in.
- R8: With dir_bkpl = 1 (backplane side), a transmit position puts gen_bit on bp_rx_out one cycle later. net_tx_out always repeats bp_tx_in, and the checker reads bp_tx_in.
- R9: In positions that are not transmit positions, both data outputs repeat their through inputs one cycle later.
- R10: mode_e1, dir_bkpl, the F-bit enables and both select vectors are sampled only at frame bit 0. Changes at any other bit take effect at the next frame bit 0.
- R11: gen_en is combinational and belongs to the current bit, and gen_bit is taken in that same cycle. The data outputs and chk_en/chk_bit are registered and have exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | High in the cycle of frame bit 0 |
| mode_e1 | input | 1 | 0 = T1 framing, 1 = E1 framing |
| dir_bkpl | input | 1 | 0 = attach on the network side, 1 = on the backplane side |
| tx_sel | input | NSEL | Per-slot transmit select, bit k for slot k |
| rx_sel | input | NSEL | Per-slot receive select, bit k for slot k |
| tx_fbit_en | input | 1 | T1: map the F-bit to the generator |
| rx_fbit_en | input | 1 | T1: map the F-bit to the checker |
| bp_tx_in | input | 1 | Serial data from the backplane toward the line |
| net_tx_out | output | 1 | Serial data to the line |
| net_rx_in | input | 1 | Serial data from the line toward the backplane |
| bp_rx_out | output | 1 | Serial data to the backplane |
| gen_bit | input | 1 | Current generator bit |
| gen_en | output | 1 | Generator bit is used in this cycle |
| chk_bit | output | 1 | Bit steered to the checker |
| chk_en | output | 1 | chk_bit is valid |

## Verification
Directed frames in both modes use single selected slots at the edges of the slot range, such as slot 0, slot 23 and slot 31. These show an off-by-one in the slot boundaries, F-bit handling that leaks into E1, and T1 frames that run past slot 23. Runs with F-bit enables that disagree per direction, and with opposite transmit and receive masks, show whether the two directions are decoded independently. Random select vectors and random data on all three serial inputs, in both directions, show a swapped source or destination side. Configuration changes and extra frame syncs at random mid-frame points show whether settings are applied only at frame boundaries and whether the count restarts correctly.

// File: rtl/tsgate_pkg.sv
package tsgate_pkg;

    typedef enum logic [1:0] {
        POS_HUNT    = 2'd0,
        POS_FBIT    = 2'd1,
        POS_PAYLOAD = 2'd2
    } pos_state_e;

    typedef struct packed {
        logic mode_e1;
        logic dir_bkpl;
        logic tx_fen;
        logic rx_fen;
    } gate_ctl_t;

endpackage

// File: rtl/tsg_frame_pos.sv
module tsg_frame_pos
    import tsgate_pkg::*;
#(
    parameter int T1_SLOTS  = 24,
    parameter int E1_SLOTS  = 32,
    parameter int SLOT_BITS = 8,
    localparam int SW = $clog2(E1_SLOTS),
    localparam int BW = $clog2(SLOT_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    input  logic          mode_e1_act,
    output logic          cur_start,
    output pos_state_e    cur_state,
    output logic [SW-1:0] cur_slot
);
    localparam logic [SW-1:0] T1_LAST  = SW'(T1_SLOTS - 1);
    localparam logic [SW-1:0] E1_LAST  = SW'(E1_SLOTS - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(SLOT_BITS - 1);

    pos_state_e    nxt_state_q, st_d;
    logic [SW-1:0] nxt_slot_q, slot_d;
    logic [BW-1:0] nxt_bit_q, bit_d, cur_bit;
    logic          wrap_q, wrap_d;

    // current position: a frame start overrides the stored successor
    always_comb begin
        cur_start = fsync | wrap_q;
        if (cur_start) begin
            cur_state = mode_e1_act ? POS_PAYLOAD : POS_FBIT;
            cur_slot  = '0;
            cur_bit   = '0;
        end else begin
            cur_state = nxt_state_q;
            cur_slot  = nxt_slot_q;
            cur_bit   = nxt_bit_q;
        end
    end

    // successor position
    always_comb begin
        st_d   = cur_state;
        slot_d = cur_slot;
        bit_d  = cur_bit;
        wrap_d = 1'b0;
        unique case (cur_state)
            POS_HUNT: begin
                st_d = POS_HUNT;
            end
            POS_FBIT: begin
                st_d   = POS_PAYLOAD;
                slot_d = '0;
                bit_d  = '0;
            end
            POS_PAYLOAD: begin
                if (cur_bit == BIT_LAST) begin
                    bit_d = '0;
                    if (cur_slot == (mode_e1_act ? E1_LAST : T1_LAST)) begin
                        wrap_d = 1'b1;
                    end else begin
                        slot_d = cur_slot + SW'(1);
                    end
                end else begin
                    bit_d = cur_bit + BW'(1);
                end
            end
            default: begin
                st_d = POS_HUNT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_state_q <= POS_HUNT;
            nxt_slot_q  <= '0;
            nxt_bit_q   <= '0;
            wrap_q      <= 1'b0;
        end else begin
            nxt_state_q <= st_d;
            nxt_slot_q  <= slot_d;
            nxt_bit_q   <= bit_d;
            wrap_q      <= wrap_d;
        end
    end

endmodule

// File: rtl/tsg_cfg_hold.sv
module tsg_cfg_hold
    import tsgate_pkg::*;
#(
    parameter int NSEL = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cur_start,
    input  gate_ctl_t       ctl_live,
    input  logic [NSEL-1:0] tx_sel_live,
    input  logic [NSEL-1:0] rx_sel_live,
    output gate_ctl_t       ctl_act,
    output logic [NSEL-1:0] tx_sel_act,
    output logic [NSEL-1:0] rx_sel_act
);
    gate_ctl_t       ctl_q;
    logic [NSEL-1:0] tx_q, rx_q;

    always_comb begin
        ctl_act    = cur_start ? ctl_live    : ctl_q;
        tx_sel_act = cur_start ? tx_sel_live : tx_q;
        rx_sel_act = cur_start ? rx_sel_live : rx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else if (cur_start) begin
            ctl_q <= ctl_live;
            tx_q  <= tx_sel_live;
            rx_q  <= rx_sel_live;
        end
    end

endmodule

// File: rtl/tsg_slot_map.sv
module tsg_slot_map
    import tsgate_pkg::*;
#(
    parameter int NSEL = 32,
    localparam int SW = $clog2(NSEL)
) (
    input  pos_state_e      cur_state,
    input  logic [SW-1:0]   cur_slot,
    input  gate_ctl_t       ctl_act,
    input  logic [NSEL-1:0] tx_sel_act,
    input  logic [NSEL-1:0] rx_sel_act,
    output logic            tx_map,
    output logic            rx_map
);
    always_comb begin
        unique case (cur_state)
            POS_FBIT: begin
                tx_map = ctl_act.tx_fen & ~ctl_act.mode_e1;
                rx_map = ctl_act.rx_fen & ~ctl_act.mode_e1;
            end
            POS_PAYLOAD: begin
                tx_map = tx_sel_act[cur_slot];
                rx_map = rx_sel_act[cur_slot];
            end
            default: begin
                tx_map = 1'b0;
                rx_map = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tsg_merge.sv
module tsg_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_map,
    input  logic rx_map,
    input  logic dir_bkpl,
    input  logic gen_bit,
    input  logic bp_tx_in,
    input  logic net_rx_in,
    output logic net_tx_out,
    output logic bp_rx_out,
    output logic chk_bit,
    output logic chk_en
);
    logic use_net, use_bkpl, src_bit;

    always_comb begin
        use_net  = tx_map & ~dir_bkpl;
        use_bkpl = tx_map & dir_bkpl;
        src_bit  = dir_bkpl ? bp_tx_in : net_rx_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            net_tx_out <= 1'b0;
            bp_rx_out  <= 1'b0;
            chk_bit    <= 1'b0;
            chk_en     <= 1'b0;
        end else begin
            net_tx_out <= use_net  ? gen_bit : bp_tx_in;
            bp_rx_out  <= use_bkpl ? gen_bit : net_rx_in;
            chk_en     <= rx_map;
            chk_bit    <= rx_map & src_bit;
        end
    end

endmodule

// File: rtl/bert_slot_gate.sv
module bert_slot_gate
    import tsgate_pkg::*;
#(
    parameter int T1_SLOTS  = 24,
    parameter int NSEL      = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fsync,
    input  logic            mode_e1,
    input  logic            dir_bkpl,
    input  logic [NSEL-1:0] tx_sel,
    input  logic [NSEL-1:0] rx_sel,
    input  logic            tx_fbit_en,
    input  logic            rx_fbit_en,
    input  logic            bp_tx_in,
    output logic            net_tx_out,
    input  logic            net_rx_in,
    output logic            bp_rx_out,
    input  logic            gen_bit,
    output logic            gen_en,
    output logic            chk_bit,
    output logic            chk_en
);
    localparam int SW = $clog2(NSEL);

    gate_ctl_t       ctl_live, ctl_act;
    logic [NSEL-1:0] tx_sel_act, rx_sel_act;
    logic            cur_start;
    pos_state_e      cur_state;
    logic [SW-1:0]   cur_slot;
    logic            tx_map_w, rx_map_w, dir_act;

    always_comb begin
        ctl_live.mode_e1  = mode_e1;
        ctl_live.dir_bkpl = dir_bkpl;
        ctl_live.tx_fen   = tx_fbit_en;
        ctl_live.rx_fen   = rx_fbit_en;
        dir_act           = ctl_act.dir_bkpl;
        gen_en            = tx_map_w;
    end

    tsg_frame_pos #(
        .T1_SLOTS (T1_SLOTS),
        .E1_SLOTS (NSEL),
        .SLOT_BITS(SLOT_BITS)
    ) i_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .mode_e1_act(ctl_act.mode_e1),
        .cur_start  (cur_start),
        .cur_state  (cur_state),
        .cur_slot   (cur_slot)
    );

    tsg_cfg_hold #(.NSEL(NSEL)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_start  (cur_start),
        .ctl_live   (ctl_live),
        .tx_sel_live(tx_sel),
        .rx_sel_live(rx_sel),
        .ctl_act    (ctl_act),
        .tx_sel_act (tx_sel_act),
        .rx_sel_act (rx_sel_act)
    );

    tsg_slot_map #(.NSEL(NSEL)) i_map (
        .cur_state (cur_state),
        .cur_slot  (cur_slot),
        .ctl_act   (ctl_act),
        .tx_sel_act(tx_sel_act),
        .rx_sel_act(rx_sel_act),
        .tx_map    (tx_map_w),
        .rx_map    (rx_map_w)
    );

    tsg_merge i_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_map    (tx_map_w),
        .rx_map    (rx_map_w),
        .dir_bkpl  (dir_act),
        .gen_bit   (gen_bit),
        .bp_tx_in  (bp_tx_in),
        .net_rx_in (net_rx_in),
        .net_tx_out(net_tx_out),
        .bp_rx_out (bp_rx_out),
        .chk_bit   (chk_bit),
        .chk_en    (chk_en)
    );

endmodule

// File: rtl/bert_slot_gate_chk.sv
module bert_slot_gate_chk #(
    parameter int NSEL = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fsync,
    input logic            mode_e1,
    input logic [NSEL-1:0] tx_sel,
    input logic            tx_fbit_en,
    input logic            bp_tx_in,
    input logic            net_tx_out,
    input logic            net_rx_in,
    input logic            bp_rx_out,
    input logic            gen_bit,
    input logic            gen_en,
    input logic            chk_bit,
    input logic            chk_en,
    input logic            rx_map_w,
    input logic            dir_act
);
    p_net_insert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !dir_act) |=> (net_tx_out == $past(gen_bit)) && (bp_rx_out == $past(net_rx_in)));

    p_bkpl_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && dir_act) |=> (bp_rx_out == $past(gen_bit)) && (net_tx_out == $past(bp_tx_in)));

    p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (net_tx_out == $past(bp_tx_in)) && (bp_rx_out == $past(net_rx_in)));

    p_checker_feed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_map_w |=> chk_en && (chk_bit == $past(dir_act ? bp_tx_in : net_rx_in)));

    p_checker_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_map_w |=> !chk_en && !chk_bit);

    p_t1_fbit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !mode_e1) |-> (gen_en == tx_fbit_en));

    p_e1_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && mode_e1) |-> (gen_en == tx_sel[0]));

endmodule

bind bert_slot_gate bert_slot_gate_chk #(.NSEL(NSEL)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .mode_e1   (mode_e1),
    .tx_sel    (tx_sel),
    .tx_fbit_en(tx_fbit_en),
    .bp_tx_in  (bp_tx_in),
    .net_tx_out(net_tx_out),
    .net_rx_in (net_rx_in),
    .bp_rx_out (bp_rx_out),
    .gen_bit   (gen_bit),
    .gen_en    (gen_en),
    .chk_bit   (chk_bit),
    .chk_en    (chk_en),
    .rx_map_w  (rx_map_w),
    .dir_act   (dir_act)
);

// File: tb/test_bert_slot_gate.sv
`timescale 1ns/1ps
module test_bert_slot_gate;
    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0, mode_e1 = 1'b0, dir_bkpl = 1'b0;
    logic [31:0] tx_sel = '0, rx_sel = '0;
    logic        tx_fbit_en = 1'b0, rx_fbit_en = 1'b0;
    logic        bp_tx_in = 1'b0, net_rx_in = 1'b0, gen_bit = 1'b0;
    logic        net_tx_out, bp_rx_out, gen_en, chk_bit, chk_en;

    int checks = 0, failures = 0;
    bit done = 0;
    string phase = "R1 reset";

    always #(CLK_NS/2) clk = ~clk;

    bert_slot_gate i_bert_slot_gate (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .mode_e1(mode_e1), .dir_bkpl(dir_bkpl),
        .tx_sel(tx_sel), .rx_sel(rx_sel), .tx_fbit_en(tx_fbit_en), .rx_fbit_en(rx_fbit_en),
        .bp_tx_in(bp_tx_in), .net_tx_out(net_tx_out), .net_rx_in(net_rx_in),
        .bp_rx_out(bp_rx_out), .gen_bit(gen_bit), .gen_en(gen_en),
        .chk_bit(chk_bit), .chk_en(chk_en)
    );

    // reference position model built from R2, R5, R6, R10
    int   m_state = 0;   // 0 hunt, 1 F-bit, 2 payload
    int   m_slot = 0, m_bit = 0;
    bit   m_wrap = 0;
    bit   c_e1 = 0, c_dir = 0, c_tf = 0, c_rf = 0;
    logic [31:0] c_tx = '0, c_rx = '0;
    bit   e_net, e_bkp, e_chk_en, e_chk_bit;
    string t_gen, t_net, t_bkp;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s [%s] %s: actual=%0d expected=%0d", tag, phase, what, act, exp);
        end
    endtask

    task automatic model_cycle(output bit x_tx, output bit x_rx);
        bit st;
        int cs, cslot, cbit;
        st = fsync || m_wrap;
        if (st) begin
            c_e1 = mode_e1; c_dir = dir_bkpl; c_tf = tx_fbit_en; c_rf = rx_fbit_en;
            c_tx = tx_sel; c_rx = rx_sel;
            cs = c_e1 ? 2 : 1; cslot = 0; cbit = 0;
        end else begin
            cs = m_state; cslot = m_slot; cbit = m_bit;
        end
        x_tx = (cs == 1) ? (c_tf && !c_e1) : (cs == 2) ? c_tx[cslot] : 1'b0;
        x_rx = (cs == 1) ? (c_rf && !c_e1) : (cs == 2) ? c_rx[cslot] : 1'b0;
        t_gen = (cs == 0) ? "R1" : (cs == 1) ? "R5" : (c_e1 && cslot == 0) ? "R6" : "R3";
        m_wrap = 0; m_state = cs; m_slot = cslot; m_bit = cbit;
        if (cs == 1) begin
            m_state = 2; m_slot = 0; m_bit = 0;
        end else if (cs == 2) begin
            if (cbit == 7) begin
                m_bit = 0;
                if (cslot == (c_e1 ? 31 : 23)) m_wrap = 1;
                else m_slot = cslot + 1;
            end else begin
                m_bit = cbit + 1;
            end
        end
    endtask

    // inputs are already set at a negedge; check gen_en now (R11), then outputs at the next negedge
    task automatic tick();
        bit x_tx, x_rx;
        #1;
        model_cycle(x_tx, x_rx);
        check(t_gen, "gen_en", gen_en, x_tx);
        e_net     = (x_tx && !c_dir) ? gen_bit : bp_tx_in;
        e_bkp     = (x_tx &&  c_dir) ? gen_bit : net_rx_in;
        e_chk_en  = x_rx;
        e_chk_bit = x_rx ? (c_dir ? bp_tx_in : net_rx_in) : 1'b0;
        t_net = (x_tx && !c_dir) ? "R7" : (m_state == 0) ? "R1" : c_dir ? "R8" : "R9";
        t_bkp = (x_tx &&  c_dir) ? "R8" : (m_state == 0) ? "R1" : c_dir ? "R9" : "R7";
        @(negedge clk);
        check(t_net, "net_tx_out", net_tx_out, e_net);
        check(t_bkp, "bp_rx_out", bp_rx_out, e_bkp);
        check("R4", "chk_en", chk_en, e_chk_en);
        check("R4", "chk_bit", chk_bit, e_chk_bit);
    endtask

    task automatic rand_data();
        bp_tx_in  = 1'($urandom);
        net_rx_in = 1'($urandom);
        gen_bit   = 1'($urandom);
    endtask

    task automatic rand_cfg();
        mode_e1 = 1'($urandom); dir_bkpl = 1'($urandom);
        tx_fbit_en = 1'($urandom); rx_fbit_en = 1'($urandom);
        tx_sel = $urandom; rx_sel = $urandom;
    endtask

    // n cycles; frame sync at cycle 0 when first_sync, then random syncs / config changes per mille
    task automatic run(input int n, input bit first_sync, input int fs_pm, input int cfg_pm);
        for (int i = 0; i < n; i++) begin
            rand_data();
            fsync = (i == 0 && first_sync) || (int'($urandom % 1000) < fs_pm);
            if (int'($urandom % 1000) < cfg_pm) rand_cfg();
            tick();
        end
        fsync = 1'b0;
    endtask

    task automatic set_cfg(input bit e1, input bit dir, input bit tf, input bit rf,
                           input logic [31:0] tx, input logic [31:0] rx);
        mode_e1 = e1; dir_bkpl = dir; tx_fbit_en = tf; rx_fbit_en = rf; tx_sel = tx; rx_sel = rx;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h0BE5_7A11);
        // R1: registered outputs are 0 in reset
        repeat (3) @(negedge clk);
        check("R1", "net_tx_out in reset", net_tx_out, 0);
        check("R1", "bp_rx_out in reset", bp_rx_out, 0);
        check("R1", "chk_en in reset", chk_en, 0);
        check("R1", "gen_en in reset", gen_en, 0);
        rst_n = 1'b1;
        // R1: hunting, no frame sync yet, selects all on
        phase = "R1 hunt";
        set_cfg(0, 0, 1, 1, '1, '1);
        run(40, 0, 0, 0);

        // R2 R3 R5 R7: T1 network side, edge slots, tx F-bit only; free-running over 3 frames
        phase = "R2 T1 net edge slots";
        set_cfg(0, 0, 1, 0, 32'h0080_0001, 32'h0000_0002);
        run(193 * 3 + 5, 1, 0, 0);
        // R5: opposite F-bit enables, opposite masks, T1 bits 24..31 set (must be unused)
        phase = "R5 T1 rx F-bit";
        set_cfg(0, 0, 0, 1, 32'hFF00_0002, 32'h0080_0001);
        run(193 * 2, 1, 0, 0);
        // R6 R8: E1 backplane, slot 0 and slot 31, F-bit enables on (no effect)
        phase = "R6 E1 bkpl";
        set_cfg(1, 1, 1, 1, 32'h8000_0001, 32'h4000_0001);
        run(256 * 2 + 3, 1, 0, 0);
        // R8: E1 backplane random masks
        phase = "R8 E1 bkpl random";
        set_cfg(1, 1, 0, 0, $urandom, $urandom);
        run(256 * 2, 1, 0, 0);
        // R10: config changes often mid-frame, applied only at bit 0
        phase = "R10 midframe changes";
        rand_cfg();
        run(256 * 6, 1, 0, 40);
        // R2: frame sync in the middle of a frame restarts the count
        phase = "R2 midframe sync";
        set_cfg(0, 0, 1, 1, 32'h0000_0101, 32'h0000_1010);
        run(100, 1, 0, 0);
        run(300, 1, 0, 0);
        set_cfg(1, 0, 0, 0, 32'h0001_0000, 32'h0002_0000);
        run(300, 1, 0, 0);
        // mixed random: everything changes at random points (R2 R3 R4 R7 R8 R9 R10 R11)
        phase = "R11 random mix";
        for (int k = 0; k < 20; k++) begin
            rand_cfg();
            run(400, 1, 3, 10);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule